// File: doc/BRIEF.md
# Stored Configuration Image Header Checker

This block inspects a stored configuration image record as it streams past, one byte per accepted beat, before any device loading is allowed to begin. A start pulse arms it. It then checks a three-character signature, captures the stored CRC and the declared total record length, rejects lengths outside fixed bounds, and reads the filename length. It steps over the filename and runs a CRC-32 across the payload that follows it.

When the record is decided, the block pulses `done` for one cycle and holds a result code, a pass flag, the payload start offset and the payload length until the next start pulse. The first failure ends the check. Bytes offered after the decision are refused, so an upstream reader can stop fetching as soon as `in_ready` drops.

Top module: `img_hdr_check`

## Requirements
- R1: A `start` pulse clears `ok`, `err_code`, `pay_off` and `pay_len`, raises `busy` on the next cycle, and `in_ready` is high while `busy` is high and `start` is low. `start` restarts a parse even while one is running.
- R2: Bytes 0, 1 and 2 must equal 0x77, 0x37 and 0x6F. The first byte that differs ends the check with code 1 (header fault).
- R3: Bytes 4..7 hold the stored CRC and bytes 8..11 hold the total record length, both most significant byte first. The values of bytes 3 and 12 have no effect on the result.
- R4: A total length of zero, below `MIN_LEN` (default 0x133A4) or above `MAX_LEN` (default 0x7FFFF) ends the check with code 1 when byte 11 is accepted. Lengths equal to either bound are accepted.
- R5: Byte 13 is the filename length F. The reported payload offset is 14+F, and the reported payload length is the total length minus 14 minus F.
- R6: The byte at index total length minus one ends the check. The CRC-32 (reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF, final inversion) of bytes 14+F up to that byte is compared with the stored CRC. A match gives code 0 with `ok`=1; a mismatch gives code 2 with `ok`=0.
- R7: `done` is high for exactly one cycle, the cycle after the deciding byte is accepted. The result outputs keep their values until the next `start`.
- R8: After the decision, `in_ready` stays low and further bytes offered on the stream leave every output unchanged.
- R9: A byte accepted with `in_last`=1 before the byte at index total length minus one ends the check with code 3 (short record). A header fault found on the same byte takes priority.
- R10: If `start` arrives in the middle of a parse, the parse is dropped and the next record is checked from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms a new check |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Block will accept the byte |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte the source will send |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle result strobe |
| ok | output | 1 | Record passed all checks |
| err_code | output | 2 | 0 pass, 1 header fault, 2 CRC mismatch, 3 short record |
| pay_off | output | 9 | Payload start offset (14 + filename length) |
| pay_len | output | LW | Payload length, LW = $clog2(MAX_LEN+1) |

## Verification
The bench sends records at exactly the minimum and maximum length and just outside each bound. A checker with off-by-one bounds would accept or reject these wrongly. It uses filenames of length 0 and 255, so a payload window placed wrongly would hash the wrong bytes and report a CRC mismatch on a good record. It ends records short, both inside the header and inside the payload, and inserts idle gaps in the stream. A design that miscounted beats would give its verdict on the wrong cycle or miss the short record. It also keeps offering bytes after each decision and restarts mid-record, which exposes any block that keeps consuming input or carries stale CRC state into the next parse.

// File: rtl/img_hdr_check.sv
module img_hdr_check #(
  parameter int unsigned MIN_LEN = 32'h133A4,
  parameter int unsigned MAX_LEN = 32'h7FFFF,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic [1:0]    err_code,
  output logic [8:0]    pay_off,
  output logic [LW-1:0] pay_len
);
  localparam logic [31:0] POLY = 32'hEDB88320;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  logic          running;
  logic [LW-1:0] idx;
  logic [31:0]   crc_st, crc_ref, len_sh;

  logic        acc, sig_bad, len_bad, at_end, in_pay, crc_good, fin;
  logic [7:0]  sig_exp;
  logic [31:0] len_full, crc_nxt, crc_fin;
  logic [1:0]  verdict;

  assign busy     = running;
  assign in_ready = running & ~start;
  assign acc      = in_valid & in_ready;

  assign sig_exp  = (idx == 0) ? 8'h77 : (idx == 1) ? 8'h37 : 8'h6F;
  assign sig_bad  = (32'(idx) < 3) && (in_data != sig_exp);
  assign len_full = {len_sh[23:0], in_data};
  assign len_bad  = (32'(idx) == 11) &&
                    (len_full == 0 || len_full < MIN_LEN || len_full > MAX_LEN);
  assign at_end   = (32'(idx) >= 13) && (32'(idx) + 32'd1 == len_sh);
  assign in_pay   = (32'(idx) > 13) && (32'(idx) >= 32'(pay_off));
  assign crc_nxt  = crc_step(crc_st, in_data);
  assign crc_fin  = in_pay ? crc_nxt : crc_st;
  assign crc_good = (~crc_fin == crc_ref);
  assign fin      = sig_bad | len_bad | at_end | in_last;
  assign verdict  = (sig_bad | len_bad) ? 2'd1 :
                    at_end              ? (crc_good ? 2'd0 : 2'd2) :
                                          2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      idx      <= '0;
      crc_st   <= '1;
      crc_ref  <= '0;
      len_sh   <= '0;
      done     <= 1'b0;
      ok       <= 1'b0;
      err_code <= 2'd0;
      pay_off  <= '0;
      pay_len  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        running  <= 1'b1;
        idx      <= '0;
        crc_st   <= '1;
        crc_ref  <= '0;
        len_sh   <= '0;
        ok       <= 1'b0;
        err_code <= 2'd0;
        pay_off  <= '0;
        pay_len  <= '0;
      end else if (acc) begin
        idx <= idx + 1'b1;
        if (32'(idx) >= 4 && 32'(idx) <= 7) crc_ref <= {crc_ref[23:0], in_data};
        if (32'(idx) >= 8 && 32'(idx) <= 11) len_sh <= len_full;
        if (32'(idx) == 13) begin
          pay_off <= 9'd14 + {1'b0, in_data};
          pay_len <= LW'(len_sh - 32'd14 - {24'd0, in_data});
        end
        if (in_pay) crc_st <= crc_nxt;
        if (fin) begin
          running  <= 1'b0;
          done     <= 1'b1;
          err_code <= verdict;
          ok       <= (verdict == 2'd0);
        end
      end
    end
  end
endmodule

// File: rtl/hdr_check_sva.sv
module hdr_check_sva #(parameter int LW = 20) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          in_ready,
  input logic          busy,
  input logic          done,
  input logic          ok,
  input logic [1:0]    err_code,
  input logic [LW-1:0] pay_len
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_start_no_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && busy && !ok && err_code == 2'd0));
  assert_ok_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (err_code == 2'd0));
  assert_ready_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |-> !in_ready);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(ok) && $stable(err_code) && $stable(pay_len)));
endmodule

bind img_hdr_check hdr_check_sva #(.LW(LW)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready), .busy(busy),
  .done(done), .ok(ok), .err_code(err_code), .pay_len(pay_len));

// File: tb/tb_img_hdr_check.sv
module tb_img_hdr_check;
  localparam int unsigned MINL = 300;
  localparam int unsigned MAXL = 2000;
  localparam int LW = $clog2(MAXL + 1);

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic in_ready, busy, done, ok;
  logic [1:0] err_code;
  logic [8:0] pay_off;
  logic [LW-1:0] pay_len;
  int total = 0, bad = 0;
  logic [7:0] rec[$];

  always #10 clk = ~clk;

  img_hdr_check #(.MIN_LEN(MINL), .MAX_LEN(MAXL)) dut (.*);

  task automatic chk(input bit cond, input string tag, input longint act, input longint exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int from, input int to);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = from; i <= to; i++) begin
      c ^= {24'd0, rec[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic build(input int unsigned lenf, input int fn, input int size,
                       input bit flip, input int sigbad, input logic [7:0] junk);
    logic [31:0] c;
    rec.delete();
    for (int i = 0; i < size; i++) rec.push_back(8'((i * 7 + 3) ^ (i >> 3)));
    rec[0] = 8'h77; rec[1] = 8'h37; rec[2] = 8'h6F; rec[3] = junk; rec[12] = ~junk;
    if (sigbad >= 0) rec[sigbad] = rec[sigbad] ^ 8'h20;
    {rec[8], rec[9], rec[10], rec[11]} = lenf;
    rec[13] = 8'(fn);
    c = (14 + fn <= size - 1) ? ref_crc(14 + fn, size - 1) : 32'h0;
    if (flip) c ^= 32'h0001_0000;
    {rec[4], rec[5], rec[6], rec[7]} = c;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy && !done && !ok && err_code == 0, "R1 start", {busy, done, ok, err_code}, 5'b10000);
  endtask

  task automatic run(input int lidx, input bit gap, input string tag);
    int code = -1, endi = -1, poff = 0, plen = 0;
    int unsigned L = 0;
    for (int i = 0; i < rec.size(); i++) begin
      if (i < 3 && rec[i] != (i == 0 ? 8'h77 : i == 1 ? 8'h37 : 8'h6F)) begin code = 1; endi = i; break; end
      if (i == 11) begin
        L = {rec[8], rec[9], rec[10], rec[11]};
        if (L == 0 || L < MINL || L > MAXL) begin code = 1; endi = i; break; end
      end
      if (i >= 13 && i == L - 1) begin
        poff = 14 + rec[13]; plen = L - poff;
        code = (ref_crc(poff, L - 1) == {rec[4], rec[5], rec[6], rec[7]}) ? 0 : 2;
        endi = i; break;
      end
      if (i == lidx) begin code = 3; endi = i; break; end
    end
    pulse_start();
    for (int i = 0; i < rec.size(); i++) begin
      if (gap && i % 3 == 1) begin
        in_valid = 0;
        @(negedge clk);
        chk(!done, {tag, " R7 idle"}, done, 0);
      end
      in_valid = 1; in_data = rec[i]; in_last = (i == lidx);
      #1;
      if (i <= endi) chk(in_ready, {tag, " R1 ready"}, in_ready, 1);
      else chk(!in_ready, {tag, " R8 ready"}, in_ready, 0);
      @(negedge clk);
      if (i == endi) begin
        chk(done, {tag, " R7 done"}, done, 1);
        chk(err_code == 2'(code), tag, err_code, code);
        chk(ok == (code == 0), {tag, " R6 ok"}, ok, code == 0);
        if (code == 0 || code == 2) begin
          chk(pay_off == 9'(poff), {tag, " R5 off"}, pay_off, poff);
          chk(pay_len == LW'(plen), {tag, " R5 len"}, pay_len, plen);
        end
      end else begin
        chk(!done, {tag, " R7 quiet"}, done, 0);
        if (i > endi) chk(err_code == 2'(code) && ok == (code == 0), {tag, " R8 hold"}, err_code, code);
      end
      if (i > endi + 4) break;
    end
    in_valid = 0; in_last = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R7 actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk(!busy && !done && !in_ready && !ok && err_code == 0, "reset R1", {busy, done, in_ready}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    build(400, 5, 400, 0, -1, 8'h00); run(-1, 0, "R6 pass");
    build(400, 5, 400, 0, -1, 8'hFF); run(-1, 0, "R3 junk");
    build(MINL, 0, MINL, 0, -1, 8'h11); run(-1, 1, "R4 min");
    build(MAXL, 255, MAXL, 0, -1, 8'h22); run(-1, 0, "R4 max");
    build(MINL - 1, 0, 40, 0, -1, 8'h0); run(-1, 0, "R4 low");
    build(MAXL + 1, 0, 40, 0, -1, 8'h0); run(-1, 0, "R4 high");
    build(0, 0, 40, 0, -1, 8'h0); run(-1, 0, "R4 zero");
    build(400, 3, 400, 0, 1, 8'h0); run(-1, 0, "R2 sig1");
    build(400, 3, 400, 0, 2, 8'h0); run(-1, 0, "R2 sig2");
    build(500, 9, 500, 1, -1, 8'h0); run(-1, 1, "R6 crc");
    build(400, 5, 400, 0, -1, 8'h0); run(200, 0, "R9 payload");
    build(400, 5, 400, 0, -1, 8'h0); run(5, 0, "R9 header");
    build(400, 5, 400, 0, 0, 8'h0); run(0, 0, "R9 prio");
    build(700, 20, 700, 0, -1, 8'h0);
    pulse_start();
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); in_valid = 1; in_data = rec[i];
    end
    @(negedge clk); in_valid = 0;
    chk(!done && busy, "R10 partial", done, 0);
    build(350, 7, 350, 0, -1, 8'h3C); run(-1, 1, "R10 restart");
    repeat (3) @(negedge clk);
    in_valid = 1; in_data = 8'h77;
    repeat (3) @(negedge clk);
    chk(!done && ok && err_code == 0 && pay_len == LW'(350 - 21), "R8 idle", err_code, 0);
    in_valid = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule